// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the software-visible configuration store for a 16-pin general-purpose I/O port. A 32-bit, word-only register bus writes and reads the per-pin direction mode, the push-pull or open-drain choice, the pull selection and the output data. It also stores speed, lock, alternate-function and analog-switch settings, which are kept and read back but act on nothing. A separate pin resolver takes the mode, output-type, pull and output-data words from this block. It returns the resolved pin levels, which the block samples into a read-only input data register.

Output bits can be changed without a read-modify-write sequence, in two ways. A combined strobe register carries a clear mask in its upper half and a set mask in its lower half. A second strobe register only clears. Both strobe registers read as zero. An access that is not word aligned, or that falls outside the twelve defined words, reads as zero and raises a one-cycle error flag.

Top module: `gpio_port_regs`

## Requirements
- R1: While rst_ni is low and right after it rises, the output type, output data, input data, lock, both alternate-function and analog words are 0. The mode, speed and pull words hold the MODE_RST, SPEED_RST and PULL_RST parameters.
- R2: Writes of full 32-bit values at offsets 0x00 (mode), 0x08 (speed), 0x0C (pull), 0x20 (alt-function low) and 0x24 (alt-function high) read back unchanged.
- R3: Writes at 0x04 (output type), 0x14 (output data), 0x1C (lock) and 0x2C (analog) store only bits 15:0, and bits 31:16 read back as 0.
- R4: A write at 0x18 clears every output bit whose bit in wdata[31:16] is 1 and then sets every output bit whose bit in wdata[15:0] is 1, so set wins when both are 1 for a pin.
- R5: A write at 0x28 clears every output bit whose bit in wdata[15:0] is 1. Bits 31:16 of that write have no effect.
- R6: Reads at 0x18 and 0x28 return 0.
- R7: The word at 0x10 returns pin_in_i as it was sampled at the clock edge before the read request. Writes to 0x10 change no register.
- R8: A read request accepted on one edge gives rsp_valid_o high, with its data, for exactly the following cycle. A write gives no response pulse.
- R9: An access with addr[1:0] nonzero, or at an offset above 0x2C, reads 0 and pulses rsp_err_o for the following cycle. A write of that kind changes no register. Valid offsets never raise rsp_err_o.
- R10: mode_o, otype_o, pull_o and odata_o show the stored registers from the cycle after the write. Pin p's mode field is mode_o[2p+1:2p], where 01 means output, and its pull field is pull_o[2p+1:2p].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus request strobe |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ADDR_W | Byte offset |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Bad-offset or misaligned access pulse |
| pin_in_i | input | 16 | Resolved pin levels from the pin resolver |
| mode_o | output | 32 | Per-pin 2-bit mode fields |
| otype_o | output | 16 | Per-pin open-drain select |
| pull_o | output | 32 | Per-pin 2-bit pull fields |
| odata_o | output | 16 | Output data |

## Verification
The assertions assume that each request holds for a single cycle, and that req_write_i and req_addr_i are meaningful only while req_valid_i is high. They also assume that pin_in_i is a known value at every edge. The bench drives each request for exactly one cycle from the falling edge and keeps pin_in_i defined at all times. It holds pin_in_i steady before directed reads of the input word. In its random phase it mixes misaligned and out-of-range offsets with valid ones.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned PINS     = WORD_W / 2;
  localparam int unsigned NUM_REGS = 12;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);

  // index = byte offset / 4; the offset map is software-visible
  typedef enum logic [IDX_W-1:0] {
    RI_MODE   = 4'd0,
    RI_OTYPE  = 4'd1,
    RI_SPEED  = 4'd2,
    RI_PULL   = 4'd3,
    RI_IN     = 4'd4,
    RI_OUT    = 4'd5,
    RI_SETCLR = 4'd6,
    RI_LOCK   = 4'd7,
    RI_AFLO   = 4'd8,
    RI_AFHI   = 4'd9,
    RI_CLR    = 4'd10,
    RI_ANA    = 4'd11
  } reg_idx_e;

  typedef logic [NUM_REGS-1:0][WORD_W-1:0] reg_words_t;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o,
  output logic                hit_o
);
  localparam int unsigned WA_W = ADDR_W - 2;

  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel_o[g] = aligned && (addr_i[ADDR_W-1:2] == WA_W'(g));
  end

  assign hit_o = |sel_o;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter logic [WORD_W-1:0] MODE_RST  = '0,
  parameter logic [WORD_W-1:0] SPEED_RST = '0,
  parameter logic [WORD_W-1:0] PULL_RST  = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [NUM_REGS-1:0] sel_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic [PINS-1:0]     pin_in_i,
  output reg_words_t          words_o,
  output logic [WORD_W-1:0]   mode_o,
  output logic [PINS-1:0]     otype_o,
  output logic [WORD_W-1:0]   pull_o,
  output logic [PINS-1:0]     odata_o
);
  logic [WORD_W-1:0] mode_q, speed_q, pull_q, aflo_q, afhi_q;
  logic [PINS-1:0]   otype_q, out_q, in_q, lock_q, ana_q;
  logic [PINS-1:0]   out_d;
  logic [PINS-1:0]   lo_half, hi_half;

  assign lo_half = wdata_i[PINS-1:0];
  assign hi_half = wdata_i[WORD_W-1:PINS];

  // clear first, then set: set wins on a shared pin
  always_comb begin
    out_d = out_q;
    if (wr_en_i && sel_i[RI_OUT])    out_d = lo_half;
    if (wr_en_i && sel_i[RI_SETCLR]) out_d = (out_q & ~hi_half) | lo_half;
    if (wr_en_i && sel_i[RI_CLR])    out_d = out_q & ~lo_half;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_RST;
      speed_q <= SPEED_RST;
      pull_q  <= PULL_RST;
      aflo_q  <= '0;
      afhi_q  <= '0;
      otype_q <= '0;
      out_q   <= '0;
      in_q    <= '0;
      lock_q  <= '0;
      ana_q   <= '0;
    end else begin
      in_q  <= pin_in_i;
      out_q <= out_d;
      if (wr_en_i) begin
        if (sel_i[RI_MODE])  mode_q  <= wdata_i;
        if (sel_i[RI_SPEED]) speed_q <= wdata_i;
        if (sel_i[RI_PULL])  pull_q  <= wdata_i;
        if (sel_i[RI_AFLO])  aflo_q  <= wdata_i;
        if (sel_i[RI_AFHI])  afhi_q  <= wdata_i;
        if (sel_i[RI_OTYPE]) otype_q <= lo_half;
        if (sel_i[RI_LOCK])  lock_q  <= lo_half;
        if (sel_i[RI_ANA])   ana_q   <= lo_half;
      end
    end
  end

  always_comb begin
    words_o            = '0;
    words_o[RI_MODE]   = mode_q;
    words_o[RI_OTYPE]  = {{PINS{1'b0}}, otype_q};
    words_o[RI_SPEED]  = speed_q;
    words_o[RI_PULL]   = pull_q;
    words_o[RI_IN]     = {{PINS{1'b0}}, in_q};
    words_o[RI_OUT]    = {{PINS{1'b0}}, out_q};
    words_o[RI_LOCK]   = {{PINS{1'b0}}, lock_q};
    words_o[RI_AFLO]   = aflo_q;
    words_o[RI_AFHI]   = afhi_q;
    words_o[RI_ANA]    = {{PINS{1'b0}}, ana_q};
  end

  assign mode_o  = mode_q;
  assign otype_o = otype_q;
  assign pull_o  = pull_q;
  assign odata_o = out_q;
endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path
  import gpio_port_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                write_i,
  input  logic                hit_i,
  input  logic [NUM_REGS-1:0] sel_i,
  input  reg_words_t          words_i,
  output logic                rsp_valid_o,
  output logic [WORD_W-1:0]   rsp_rdata_o,
  output logic                rsp_err_o
);
  logic [WORD_W-1:0] mux;

  // one-hot AND-OR select; an unmatched offset yields zero
  always_comb begin
    mux = '0;
    for (int i = 0; i < NUM_REGS; i++) mux |= words_i[i] & {WORD_W{sel_i[i]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= valid_i && !write_i;
      rsp_err_o   <= valid_i && !hit_i;
      if (valid_i && !write_i) rsp_rdata_o <= mux;
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 10,
  parameter logic [31:0]       MODE_RST  = 32'hABFF_FFFF,
  parameter logic [31:0]       SPEED_RST = 32'h0C00_0000,
  parameter logic [31:0]       PULL_RST  = 32'h6400_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              rsp_err_o,
  input  logic [15:0]       pin_in_i,
  output logic [31:0]       mode_o,
  output logic [15:0]       otype_o,
  output logic [31:0]       pull_o,
  output logic [15:0]       odata_o
);
  logic [NUM_REGS-1:0] sel;
  logic                hit;
  reg_words_t          words;

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (req_addr_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  gpio_cfg_regs #(
    .MODE_RST  (MODE_RST),
    .SPEED_RST (SPEED_RST),
    .PULL_RST  (PULL_RST)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (req_valid_i && req_write_i),
    .sel_i    (sel),
    .wdata_i  (req_wdata_i),
    .pin_in_i (pin_in_i),
    .words_o  (words),
    .mode_o   (mode_o),
    .otype_o  (otype_o),
    .pull_o   (pull_o),
    .odata_o  (odata_o)
  );

  gpio_rd_path u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (req_valid_i),
    .write_i     (req_write_i),
    .hit_i       (hit),
    .sel_i       (sel),
    .words_i     (words),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .rsp_err_o   (rsp_err_o)
  );
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [31:0]       req_wdata_i,
  input logic              rsp_valid_o,
  input logic [31:0]       rsp_rdata_o,
  input logic              rsp_err_o,
  input logic [31:0]       mode_o,
  input logic [15:0]       odata_o
);
  logic is_rd, is_wr;
  assign is_rd = req_valid_i && !req_write_i;
  assign is_wr = req_valid_i && req_write_i;

  a_r8_rsp_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rd |=> rsp_valid_o);
  a_r8_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_rd |=> !rsp_valid_o);
  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && req_addr_i == ADDR_W'('h18)) |=>
      ((odata_o & $past(req_wdata_i[15:0])) == $past(req_wdata_i[15:0])) &&
      ((odata_o & $past(req_wdata_i[31:16]) & ~$past(req_wdata_i[15:0])) == 16'h0));
  a_r5_clear_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && req_addr_i == ADDR_W'('h28)) |=>
      ((odata_o & $past(req_wdata_i[15:0])) == 16'h0));
  a_r6_strobes_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && (req_addr_i == ADDR_W'('h18) || req_addr_i == ADDR_W'('h28))) |=>
      rsp_rdata_o == 32'h0);
  a_r7_in_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && req_addr_i == ADDR_W'('h10)) |=> ($stable(odata_o) && $stable(mode_o)));
  a_r9_misaligned_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[1:0] != 2'b00) |=> rsp_err_o);
  a_r9_err_data_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> rsp_rdata_o == 32'h0);
  a_r9_err_only_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_err_o);
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o),
  .rsp_err_o   (rsp_err_o),
  .mode_o      (mode_o),
  .odata_o     (odata_o)
);

// File: tb/tb_gpio_port_regs.sv
module tb_gpio_port_regs;
  localparam logic [31:0] M_RST = 32'hABFF_FFFF;
  localparam logic [31:0] S_RST = 32'h0C00_0000;
  localparam logic [31:0] P_RST = 32'h6400_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] pin_in = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata, mode, pull;
  logic [15:0] otype, odata;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  gpio_port_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err), .pin_in_i(pin_in),
    .mode_o(mode), .otype_o(otype), .pull_o(pull), .odata_o(odata)
  );

  // reference model state
  logic [31:0] m_mode, m_speed, m_pull, m_aflo, m_afhi;
  logic [15:0] m_otype, m_out, m_in, m_lock, m_ana;
  logic        e_valid, e_err;
  logic [31:0] e_rdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit bad_off(input logic [9:0] a);
    return (a[1:0] != 2'b00) || (a > 10'h2C);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = M_RST; m_speed = S_RST; m_pull = P_RST; m_aflo = 0; m_afhi = 0;
      m_otype = 0; m_out = 0; m_in = 0; m_lock = 0; m_ana = 0;
      e_valid = 0; e_err = 0; e_rdata = 0;
    end else begin
      e_valid = valid && !write;
      e_err   = valid && bad_off(addr);
      if (valid && !write) begin
        e_rdata = 0;
        if (!bad_off(addr)) case (addr)
          10'h00: e_rdata = m_mode;
          10'h04: e_rdata = {16'h0, m_otype};
          10'h08: e_rdata = m_speed;
          10'h0C: e_rdata = m_pull;
          10'h10: e_rdata = {16'h0, m_in};
          10'h14: e_rdata = {16'h0, m_out};
          10'h1C: e_rdata = {16'h0, m_lock};
          10'h20: e_rdata = m_aflo;
          10'h24: e_rdata = m_afhi;
          10'h2C: e_rdata = {16'h0, m_ana};
          default: e_rdata = 0;
        endcase
      end
      if (valid && write && !bad_off(addr)) case (addr)
        10'h00: m_mode = wdata;
        10'h04: m_otype = wdata[15:0];
        10'h08: m_speed = wdata;
        10'h0C: m_pull = wdata;
        10'h14: m_out = wdata[15:0];
        10'h18: begin m_out = m_out & ~wdata[31:16]; m_out = m_out | wdata[15:0]; end
        10'h1C: m_lock = wdata[15:0];
        10'h20: m_aflo = wdata;
        10'h24: m_afhi = wdata;
        10'h28: m_out = m_out & ~wdata[15:0];
        10'h2C: m_ana = wdata[15:0];
        default: ;
      endcase
      m_in = pin_in;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_ni) begin
    chk(rsp_valid === e_valid, "R8 rsp_valid", {31'h0, rsp_valid}, {31'h0, e_valid});
    chk(rsp_err === e_err, "R9 rsp_err", {31'h0, rsp_err}, {31'h0, e_err});
    if (e_valid) chk(rsp_rdata === e_rdata, "R2 readback", rsp_rdata, e_rdata);
    chk(mode === m_mode, "R10 mode_o", mode, m_mode);
    chk(pull === m_pull, "R10 pull_o", pull, m_pull);
    chk(otype === m_otype, "R10 otype_o", {16'h0, otype}, {16'h0, m_otype});
    chk(odata === m_out, "R10 odata_o", {16'h0, odata}, {16'h0, m_out});
  end

  task automatic req(input bit w, input logic [9:0] a, input logic [31:0] d);
    valid = 1'b1; write = w; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic rd_expect(input logic [9:0] a, input logic [31:0] exp, input string tag);
    req(1'b0, a, 32'h0);
    chk(rsp_valid === 1'b1 && rsp_rdata === exp, tag, rsp_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state visible on the ports while in reset
    chk(mode === M_RST && pull === P_RST, "R1 reset mode/pull", mode, M_RST);
    chk(otype === 16'h0 && odata === 16'h0, "R1 reset otype/odata", {otype, odata}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd_expect(10'h08, S_RST, "R1 speed reset");
    rd_expect(10'h1C, 32'h0, "R1 lock reset");
    rd_expect(10'h24, 32'h0, "R1 afhi reset");
    // R2 full-width storage
    req(1'b1, 10'h20, 32'hDEAD_BEEF);
    rd_expect(10'h20, 32'hDEAD_BEEF, "R2 aflo");
    req(1'b1, 10'h00, 32'h5555_0001);
    chk(mode === 32'h5555_0001, "R10 mode_o after write", mode, 32'h5555_0001);
    // R3 upper half dropped
    req(1'b1, 10'h2C, 32'hFFFF_1234);
    rd_expect(10'h2C, 32'h0000_1234, "R3 analog upper");
    req(1'b1, 10'h14, 32'hABCD_00F0);
    rd_expect(10'h14, 32'h0000_00F0, "R3 odata upper");
    // R4 set wins over clear
    req(1'b1, 10'h18, 32'h00FF_0F0F);
    chk(odata === 16'h0F0F, "R4 set/clear", {16'h0, odata}, 32'h0F0F);
    // R5 clear-only, upper ignored
    req(1'b1, 10'h28, 32'hFFFF_0103);
    chk(odata === 16'h0E0C, "R5 clear", {16'h0, odata}, 32'h0E0C);
    // R6 strobes read zero
    rd_expect(10'h18, 32'h0, "R6 setclr read");
    rd_expect(10'h28, 32'h0, "R6 clr read");
    // R7 input sampling and ignored write
    pin_in = 16'hA5C3;
    @(negedge clk); @(negedge clk);
    req(1'b1, 10'h10, 32'h0000_FFFF);
    chk(odata === 16'h0E0C, "R7 write to input ignored", {16'h0, odata}, 32'h0E0C);
    rd_expect(10'h10, 32'h0000_A5C3, "R7 input word");
    // R9 bad offsets
    req(1'b1, 10'h30, 32'hFFFF_FFFF);
    chk(rsp_err === 1'b1 && rsp_valid === 1'b0, "R9 bad write err", {31'h0, rsp_err}, 32'h1);
    rd_expect(10'h02, 32'h0, "R9 misaligned read");
    chk(rsp_err === 1'b1, "R9 misaligned err", {31'h0, rsp_err}, 32'h1);
    rd_expect(10'h14, 32'h0000_0E0C, "R9 bad write had no effect");
    // R8 no response on write, pulse ends
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R8 single pulse", {31'h0, rsp_valid}, 32'h0);
    // random mix against the model
    for (int i = 0; i < 400; i++) begin
      logic [9:0] a;
      int sel;
      sel = $urandom_range(0, 15);
      a = (sel < 12) ? 10'(sel * 4) : (sel == 12) ? 10'h30 : (sel == 13) ? 10'h3FC
          : 10'(($urandom_range(0, 11) * 4) + $urandom_range(1, 3));
      if ($urandom_range(0, 3) == 0) pin_in = 16'($urandom);
      if ($urandom_range(0, 2) == 0) @(negedge clk);
      else req(1'($urandom_range(0, 1)), a, $urandom);
    end
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule